// File: doc/BRIEF.md
# Two-Adder Recursive Bitstream Low-Pass Filter

This block low-pass filters a stream of single-bit samples whose values are only 0 or 1, as produced by an oversampling one-bit modulator. It computes a fixed 13-tap FIR response with only two adders, whatever the filter length. Each accepted bit enters a one-bit history line. Two small words are wired straight out of that line: a gain word of taps that add to the output and a loss word of taps that subtract from it. The new output is the previous output plus the gain word minus the loss word.

The default response is 1, 3, 3, seven taps of 7, 3, 3, 1. Its steps between neighbouring coefficients are distinct signed powers of two, so each bit of the gain and loss words comes from exactly one delayed sample. Which delay feeds which word bit is a parameter. Because the input is unipolar and the coefficients sum to 63, the result always fits in 6 unsigned bits.

Samples arrive over a valid/ready handshake and results leave over another. A sample is accepted on a rising edge where `smp_valid` and `smp_ready` are both high. A result is taken on an edge where `res_valid` and `res_ready` are both high. `smp_ready` is high whenever the output slot is empty or is being drained in the same cycle. A consumer that holds `res_ready` low therefore stalls the producer, and holds the output and the history unchanged.

Top module: `bitstream_fir2add`

## Requirements
- R1: A synchronous reset clears the history line and the output register to zero and drops `res_valid`.
- R2: After each accepted bit, `res_data` equals the sum of h[k]·x[n-k] for k = 0..12, where h = 1,3,3,7,7,7,7,7,7,7,3,3,1 and x[n] is the newest accepted bit. Bits from before the last reset count as 0.
- R3: The output never wraps. A run of 13 or more accepted ones gives exactly 63, the top of the 6-bit range.
- R4: Starting from reset, a first accepted 1 gives 1, and a second consecutive 1 gives 4.
- R5: The filter state changes only on an accepted sample. Values on `smp_bit` while `smp_valid` is low have no effect on any later result.
- R6: `res_valid` is high in the cycle after a sample is accepted. It clears after a transfer on the output if no new sample is accepted in that cycle.
- R7: `smp_ready` is high exactly when `res_valid` is low or `res_ready` is high. While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold.
- R8: A run of 13 accepted zeros after any history brings the output back to 0.
- R9: A lone 1 followed by zeros produces the coefficient sequence h at the output, one value per accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Input sample present |
| smp_ready | output | 1 | Filter can accept a sample this cycle |
| smp_bit | input | 1 | Unipolar one-bit sample |
| res_valid | output | 1 | Output result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 6 | Filtered unsigned result |

## Verification
The bench builds the block with its default parameters: a 6-bit output, 3-bit gain and loss words, and the 13-tap low-pass tap map. This puts every word bit, the full 0 to 63 range and the longest delay of 13 within reach of short runs. Expected results come from a direct 13-tap convolution kept in the bench. Random streams, solid runs of ones and zeros, a lone impulse, input gaps with a toggling data bit, and output stalls are compared against it. Stalls on the output side exercise the hold and ready rules.

// File: rtl/fir2a_pkg.sv
`timescale 1ns/1ps
package fir2a_pkg;
  // width of one delay field inside a tap map
  localparam int unsigned DLY_W = 5;

  // largest delay held in a packed map of n fields
  function automatic int unsigned map_max(input logic [63:0] m, input int unsigned n);
    int unsigned best;
    best = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (int'(m[i*DLY_W +: DLY_W]) > int'(best)) best = int'(m[i*DLY_W +: DLY_W]);
    end
    return best;
  endfunction
endpackage

// File: rtl/fir2a_tapline.sv
`timescale 1ns/1ps
module fir2a_tapline #(
  parameter int unsigned HIST_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              in_bit,
  output logic [HIST_W:0]   taps
);
  // hist[k] holds the sample accepted k+1 steps ago
  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], in_bit};
  end

  // taps[k] is the sample k steps back, taps[0] the one arriving now
  assign taps = {hist, in_bit};
endmodule

// File: rtl/fir2a_wordpack.sv
`timescale 1ns/1ps
module fir2a_wordpack #(
  parameter int unsigned WORD_W = 3,
  parameter int unsigned HIST_W = 13,
  parameter logic [WORD_W*fir2a_pkg::DLY_W-1:0] MAP = '0
) (
  input  logic [HIST_W:0]   taps,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned DW = fir2a_pkg::DLY_W;

  // each word bit is a hard-wired pick of one delayed sample
  for (genvar i = 0; i < int'(WORD_W); i++) begin : g_bit
    localparam int unsigned SEL = int'(MAP[i*DW +: DW]);
    assign word[i] = taps[SEL];
  end
endmodule

// File: rtl/fir2a_accum.sv
`timescale 1ns/1ps
module fir2a_accum #(
  parameter int unsigned OUT_W  = 6,
  parameter int unsigned WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              res_ready,
  input  logic [WORD_W-1:0] gain_w,
  input  logic [WORD_W-1:0] loss_w,
  output logic [OUT_W-1:0]  y,
  output logic              y_valid
);
  // one guard bit so y + gain - loss never wraps on the way
  localparam int unsigned ACC_W = OUT_W + 1;

  logic [ACC_W-1:0] grown;
  logic [ACC_W-1:0] next_acc;

  always_comb begin
    grown    = {1'b0, y} + ACC_W'(gain_w);
    next_acc = grown - ACC_W'(loss_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y       <= '0;
      y_valid <= 1'b0;
    end else begin
      if (fire) y <= next_acc[OUT_W-1:0];
      if (fire)           y_valid <= 1'b1;
      else if (res_ready) y_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bitstream_fir2add.sv
`timescale 1ns/1ps
module bitstream_fir2add #(
  parameter int unsigned OUT_W  = 6,
  parameter int unsigned WORD_W = 3,
  // field i gives the delay feeding word bit i (MSB field written first)
  parameter logic [WORD_W*fir2a_pkg::DLY_W-1:0] GAIN_MAP = {5'd3,  5'd1,  5'd0},
  parameter logic [WORD_W*fir2a_pkg::DLY_W-1:0] LOSS_MAP = {5'd10, 5'd12, 5'd13}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             smp_bit,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [OUT_W-1:0] res_data
);
  localparam int unsigned GAIN_MAX = fir2a_pkg::map_max(64'(GAIN_MAP), WORD_W);
  localparam int unsigned LOSS_MAX = fir2a_pkg::map_max(64'(LOSS_MAP), WORD_W);
  localparam int unsigned HIST_W   = (GAIN_MAX > LOSS_MAX) ? GAIN_MAX : LOSS_MAX;

  logic              fire;
  logic [HIST_W:0]   taps;
  logic [WORD_W-1:0] gain_w;
  logic [WORD_W-1:0] loss_w;

  assign smp_ready = !res_valid || res_ready;
  assign fire      = smp_valid && smp_ready;

  fir2a_tapline #(.HIST_W(HIST_W)) u_line (
    .clk(clk), .rst(rst), .shift_en(fire), .in_bit(smp_bit), .taps(taps)
  );

  fir2a_wordpack #(.WORD_W(WORD_W), .HIST_W(HIST_W), .MAP(GAIN_MAP)) u_gain (
    .taps(taps), .word(gain_w)
  );

  fir2a_wordpack #(.WORD_W(WORD_W), .HIST_W(HIST_W), .MAP(LOSS_MAP)) u_loss (
    .taps(taps), .word(loss_w)
  );

  fir2a_accum #(.OUT_W(OUT_W), .WORD_W(WORD_W)) u_acc (
    .clk(clk), .rst(rst), .fire(fire), .res_ready(res_ready),
    .gain_w(gain_w), .loss_w(loss_w), .y(res_data), .y_valid(res_valid)
  );
endmodule

// File: rtl/fir2a_chk.sv
`timescale 1ns/1ps
module fir2a_chk #(
  parameter int unsigned OUT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [OUT_W-1:0] res_data
);
  // R1: the cycle after reset shows an empty, zeroed output
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (res_data == '0) && !res_valid);

  // R5: no accepted sample, no change of the result
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && smp_ready) |=> $stable(res_data));

  // R6: an accepted sample yields a valid result next cycle
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> res_valid);

  // R7: a stalled result holds its value and its valid
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data));

  // R7: an empty output slot always takes input
  p_ready_empty_r7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> smp_ready);
endmodule

bind bitstream_fir2add fir2a_chk #(.OUT_W(OUT_W)) i_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/test_bitstream_fir2add.sv
`timescale 1ns/1ps
module test_bitstream_fir2add;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic       smp_bit = 1'b0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [5:0] res_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  bit    xh[0:12];   // xh[k] = bit accepted k steps ago

  always #10 clk = ~clk;   // 50 MHz

  bitstream_fir2add i_bitstream_fir2add (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_bit(smp_bit), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  function automatic int coef(int k);
    if (k == 0 || k == 12) return 1;
    if (k == 1 || k == 2 || k == 10 || k == 11) return 3;
    return 7;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 13; k++) xh[k] = 1'b0;
  endtask

  // driver: offer one bit, wait until taken, push expected result
  task automatic send(bit b, string req);
    int acc;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_bit   = b;
    #1;
    while (!smp_ready) begin
      @(negedge clk);
      #1;
    end
    for (int k = 12; k > 0; k--) xh[k] = xh[k-1];
    xh[0] = b;
    acc = 0;
    for (int k = 0; k < 13; k++) acc += coef(k) * int'(xh[k]);
    exp_q.push_back(acc);
    tag_q.push_back(req);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // monitor: each negedge with a result on offer is one transfer
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check("R6", 1, 0);
        end else begin
          string t;
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'(res_data), e);
        end
      end
    end
  end

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          check("watchdog", 1, 0);
          $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
          $finish;
        end
      end
    join_none

    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 data", int'(res_data), 0);
    check("R1 valid", int'(res_valid), 0);
    check("R7 ready after reset", int'(smp_ready), 1);

    // R4 first 1 then second 1
    send(1'b1, "R4 first");
    send(1'b1, "R4 second");
    for (int i = 0; i < 13; i++) send(1'b0, "R8 decay");
    drain();
    check("R8 zero", int'(res_data), 0);

    // R9 impulse response
    send(1'b1, "R9 impulse");
    for (int i = 0; i < 13; i++) send(1'b0, "R9 impulse");

    // R3 saturation at 63 with no wrap
    for (int i = 0; i < 20; i++) send(1'b1, "R3 all ones");
    drain();
    check("R3 top", int'(res_data), 63);
    for (int i = 0; i < 14; i++) send(1'b0, "R8 all zeros");

    // R2 random streams
    for (int i = 0; i < 300; i++) send(1'($urandom_range(0, 1)), "R2 random");
    drain();

    // R5 gap with a toggling bit must not shift the history
    begin
      int held;
      held = int'(res_data);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        smp_bit = ~smp_bit;
      end
      #2;
      check("R5 gap data", int'(res_data), held);
      check("R6 valid cleared", int'(res_valid), 0);
    end
    for (int i = 0; i < 40; i++) send(1'($urandom_range(0, 1)), "R5 after gap");

    // R7 back-pressure: stall the output with a result on offer
    @(negedge clk);
    res_ready = 1'b0;
    send(1'b1, "R7 stalled item");
    begin
      int held;
      #2;
      held = int'(res_data);
      check("R7 ready low", int'(smp_ready), 0);
      smp_valid = 1'b1;
      smp_bit   = 1'b0;
      repeat (4) @(negedge clk);
      #2;
      check("R7 hold data", int'(res_data), held);
      check("R7 hold valid", int'(res_valid), 1);
      smp_valid = 1'b0;
    end
    @(negedge clk);
    res_ready = 1'b1;
    for (int i = 0; i < 40; i++) send(1'($urandom_range(0, 1)), "R7 after stall");
    drain();
    check("R2 queue empty", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule